// File: doc/BRIEF.md
# Scalable 64-bit System Counter

This block keeps a 64-bit count that downstream timers use as their shared time base. The count advances only on cycles where the input tick strobe is high. When scaling is off and counting is on, each tick adds exactly one. When scaling is on, each tick adds a programmable 8.24 fixed-point step. A 24-bit fraction sits below the integer count, so the visible count can run at a fraction or a multiple of the tick rate with no long-term drift.

Software reaches the block through a small frame of 32-bit registers. Access uses plain read and write strobes with a byte address, and there is no back-pressure: every strobe completes in the cycle it is presented. Read data is registered and appears on the cycle after the read strobe. It is zero on every other cycle. The count can be written as two 32-bit halves. Reading the low half captures the high half, so two reads in a row return one coherent 64-bit value.

Top module: `sys_count_top`

## Requirements
- R1: After reset the count is 0, counting and scaling are off, the status reads 0 and the scale register reads 0x01000000 (1.0).
- R2: While counting is off (control bit 0 = 0), ticks leave the count unchanged.
- R3: With counting on and scaling off, each tick cycle adds exactly 1 to the count, and cycles without a tick add nothing.
- R4: With counting and scaling on (control bit 2 = 1), each tick adds the 32-bit scale value to the concatenation of the count and the 24-bit fraction. With scale 0x00100000 this is one sixteenth per tick: a count of 100 becomes 110 after 160 ticks. With 0x02800000 it is 2.5 per tick.
- R5: A write to count low (0x8) or count high (0xC) replaces that half and clears the fraction. In that cycle a write takes precedence over a tick.
- R6: A read of count low returns bits 31:0 and captures bits 63:32. A later read of count high returns the captured value, even if the count has moved on since.
- R7: The control register (0x0) reads back bit 0 (enable) and bit 2 (scale enable), with all other bits 0. Status (0x4) bit 0 and the running_o pin are 1 while counting is enabled.
- R8: Registers sit at 0x0 control, 0x4 status, 0x8 count low, 0xC count high and 0x10 scale. Read data is valid the cycle after rd_en and 0 otherwise. Reads of any other address return 0, and writes to other addresses change nothing.
- R9: The count carries from bit 31 into bit 32 at the 32-bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick strobe, one per input tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address within the register frame |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en |
| count_o | output | 64 | Current count for downstream timers |
| running_o | output | 1 | High while counting is enabled |

## Verification
The count is visible at count_o on every cycle, so a wrong integer count shows up at the first clock edge after the fault. A corrupted fraction is different: it stays hidden until enough scaled ticks push a carry across the 24-bit boundary. With the slowest step used here, that can take up to sixteen ticks. A stale or wrong high-half capture shows only on the count-high read that follows a count-low read. The bench therefore compares count, running state and read data against its model on every cycle, including the cycles where reads and ticks interleave.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned OFF_CTRL   = 32'h00;
  localparam int unsigned OFF_STATUS = 32'h04;
  localparam int unsigned OFF_CNT_LO = 32'h08;
  localparam int unsigned OFF_CNT_HI = 32'h0C;
  localparam int unsigned OFF_SCALE  = 32'h10;

  typedef struct packed {
    logic scale_on;
    logic run;
  } sc_ctrl_t;
endpackage

// File: rtl/sc_regs.sv
module sc_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int FRAC_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output sc_pkg::sc_ctrl_t      ctrl_q,
  output logic [DATA_W-1:0]     scale_q
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(sc_pkg::OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SCALE = ADDR_W'(sc_pkg::OFF_SCALE);
  localparam logic [DATA_W-1:0] UNITY   = DATA_W'(1) << FRAC_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      scale_q <= UNITY;
    end else if (wr_en) begin
      if (addr == A_CTRL) begin
        ctrl_q.run      <= wdata[0];
        ctrl_q.scale_on <= wdata[2];
      end
      if (addr == A_SCALE) scale_q <= wdata;
    end
  end
endmodule

// File: rtl/sc_accum.sv
module sc_accum #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 24,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  sc_pkg::sc_ctrl_t  ctrl_i,
  input  logic [DATA_W-1:0] scale_i,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count_q
);
  localparam int ACC_W = CNT_W + FRAC_W;

  logic [FRAC_W-1:0] frac_q;
  logic [ACC_W-1:0]  acc_sum;

  assign acc_sum = {count_q, frac_q} + ACC_W'(scale_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      frac_q  <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) count_q[CNT_W-1:DATA_W] <= wdata;
      frac_q <= '0;
    end else if (tick_i && ctrl_i.run) begin
      if (ctrl_i.scale_on) {count_q, frac_q} <= acc_sum;
      else                 count_q <= count_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sc_readmux.sv
module sc_readmux #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  sc_pkg::sc_ctrl_t  ctrl_i,
  input  logic [DATA_W-1:0] scale_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_q
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(sc_pkg::OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(sc_pkg::OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_LO     = ADDR_W'(sc_pkg::OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_HI     = ADDR_W'(sc_pkg::OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_SCALE  = ADDR_W'(sc_pkg::OFF_SCALE);

  logic [DATA_W-1:0] hi_hold_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      A_CTRL:   rd_mux = DATA_W'({ctrl_i.scale_on, 1'b0, ctrl_i.run});
      A_STATUS: rd_mux = DATA_W'(ctrl_i.run);
      A_LO:     rd_mux = count_i[DATA_W-1:0];
      A_HI:     rd_mux = hi_hold_q;
      A_SCALE:  rd_mux = scale_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      hi_hold_q <= '0;
    end else begin
      rdata_q <= rd_en ? rd_mux : '0;
      if (rd_en && addr == A_LO) hi_hold_q <= count_i[CNT_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/sys_count_top.sv
module sys_count_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int FRAC_W = 24,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              running_o
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(sc_pkg::OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(sc_pkg::OFF_CNT_HI);

  sc_pkg::sc_ctrl_t  ctrl;
  logic [DATA_W-1:0] scale_q;
  logic              scale_on;
  logic              wr_lo;
  logic              wr_hi;

  assign wr_lo     = wr_en && (addr == A_LO);
  assign wr_hi     = wr_en && (addr == A_HI);
  assign running_o = ctrl.run;
  assign scale_on  = ctrl.scale_on;

  sc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl), .scale_q(scale_q)
  );

  sc_accum #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctrl_i(ctrl),
    .scale_i(scale_q), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
    .count_q(count_o)
  );

  sc_readmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rmux_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .ctrl_i(ctrl),
    .scale_i(scale_q), .count_i(count_o), .rdata_q(rdata_o)
  );
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int FRAC_W = 24,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              running_o,
  input logic              scale_on,
  input logic [DATA_W-1:0] scale_q
);
  // R1: reset holds the count at zero and counting off
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (count_o == '0 && !running_o));

  // R2: no movement while counting is off
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !wr_en) |=> $stable(count_o));

  // R3: unscaled tick adds one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !scale_on && tick_i && !wr_en) |=> count_o == $past(count_o) + CNT_W'(1));

  // R4: scaled tick adds the integer part of the step, or one more
  a_r4_scaled_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && scale_on && tick_i && !wr_en) |=>
      ((count_o - $past(count_o)) >= CNT_W'($past(scale_q) >> FRAC_W)) &&
      ((count_o - $past(count_o)) <= CNT_W'($past(scale_q) >> FRAC_W) + CNT_W'(1)));

  // R7: control write drives the running pin
  a_r7_run_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0)) |=> running_o == $past(wdata[0]));

  // R8: read data idles at zero
  a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata_o == '0);
endmodule

bind sys_count_top sc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata_o(rdata_o), .count_o(count_o),
  .running_o(running_o), .scale_on(scale_on), .scale_q(scale_q)
);

// File: tb/sys_count_top_tb_top.sv
module sys_count_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic [63:0] count_o;
  logic        running_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  longint unsigned m_cnt = 0;
  int unsigned     m_frac = 0;
  bit              m_run = 0, m_scl = 0;
  int unsigned     m_scale = 32'h0100_0000;
  int unsigned     m_hold = 0;
  int unsigned     m_rdata = 0;

  always #5 clk = ~clk;

  sys_count_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata_o(rdata_o), .count_o(count_o),
    .running_o(running_o)
  );

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model_step(input bit tk, input bit wr, input bit rd,
                            input logic [4:0] ad, input logic [31:0] wd);
    longint unsigned sum;
    m_rdata = 0;
    if (rd) begin
      case (ad)
        5'h00: m_rdata = {29'd0, m_scl, 1'b0, m_run};
        5'h04: m_rdata = {31'd0, m_run};
        5'h08: begin m_rdata = m_cnt[31:0]; m_hold = m_cnt[63:32]; end
        5'h0C: m_rdata = m_hold;
        5'h10: m_rdata = m_scale;
        default: m_rdata = 0;
      endcase
    end
    if (wr && (ad == 5'h08 || ad == 5'h0C)) begin
      if (ad == 5'h08) m_cnt = {m_cnt[63:32], wd};
      else             m_cnt = {wd, m_cnt[31:0]};
      m_frac = 0;
    end else if (tk && m_run) begin
      if (m_scl) begin
        sum = longint'(m_frac) + longint'(m_scale);
        m_cnt += sum >> 24;
        m_frac = int'(sum & 64'hFF_FFFF);
      end else m_cnt += 1;
    end
    if (wr && ad == 5'h00) begin m_run = wd[0]; m_scl = wd[2]; end
    if (wr && ad == 5'h10) m_scale = wd;
  endtask

  task automatic cyc(input bit tk, input bit wr, input bit rd,
                     input logic [4:0] ad, input logic [31:0] wd);
    tick_i = tk; wr_en = wr; rd_en = rd; addr = ad; wdata = wd;
    @(posedge clk);
    model_step(tk, wr, rd, ad, wd);
    @(negedge clk);
    tick_i = 0; wr_en = 0; rd_en = 0;
    chk({tag, " count"}, count_o, m_cnt);
    chk({tag, " running"}, {63'd0, running_o}, {63'd0, m_run});
    chk({tag, " rdata"}, {32'd0, rdata_o}, {32'd0, m_rdata});
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] wd); cyc(0, 1, 0, ad, wd); endtask
  task automatic rd(input logic [4:0] ad); cyc(0, 0, 1, ad, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 5'h00, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    chk("R1 count after reset", count_o, 64'd0);
    rd(5'h00); chk("R1 ctrl", {32'd0, rdata_o}, 64'd0);
    rd(5'h04); chk("R1 status", {32'd0, rdata_o}, 64'd0);
    rd(5'h10); chk("R1 scale", {32'd0, rdata_o}, 64'h0100_0000);
    // R2 disabled ticks
    tag = "R2"; ticks(20);
    chk("R2 count still zero", count_o, 64'd0);
    // R3 unit counting with gaps
    tag = "R3"; wr(5'h00, 32'h1); ticks(100);
    for (int i = 0; i < 6; i++) cyc(i % 2, 0, 0, 5'h00, 0);
    chk("R3 count", count_o, 64'd103);
    wr(5'h08, 32'd100); wr(5'h0C, 32'd0);
    // R7 control and status readback
    tag = "R7"; rd(5'h04); chk("R7 status running", {32'd0, rdata_o}, 64'd1);
    // R4 one-sixteenth scaling
    tag = "R4"; wr(5'h00, 0); wr(5'h10, 32'h0010_0000); wr(5'h00, 32'h5);
    rd(5'h00); chk("R7 ctrl readback", {32'd0, rdata_o}, 64'h5);
    ticks(160);
    rd(5'h08); chk("R4 sixteenth 110", {32'd0, rdata_o}, 64'd110);
    // R4 2.5 per tick, with gaps
    wr(5'h10, 32'h0280_0000); wr(5'h08, 0); wr(5'h0C, 0);
    for (int i = 0; i < 8; i++) cyc(i % 2, 0, 0, 5'h00, 0);
    chk("R4 two and a half", count_o, 64'd10);
    // R5 write wins over tick
    tag = "R5"; wr(5'h00, 32'h1); cyc(1, 1, 0, 5'h08, 32'h50);
    chk("R5 write beats tick", count_o, 64'h50);
    // R9 carry across halves, R6 coherent read
    tag = "R9"; wr(5'h0C, 32'h1); wr(5'h08, 32'hFFFF_FFF0); ticks(20);
    chk("R9 carry", count_o, 64'h2_0000_0004);
    tag = "R6"; rd(5'h08); chk("R6 low", {32'd0, rdata_o}, 64'd4);
    wr(5'h0C, 32'h7); ticks(3);
    rd(5'h0C); chk("R6 captured high", {32'd0, rdata_o}, 64'd2);
    // R8 unmapped address
    tag = "R8"; wr(5'h14, 32'hFFFF_FFFF); rd(5'h14);
    chk("R8 unmapped read", {32'd0, rdata_o}, 64'd0);
    rd(5'h10); chk("R8 scale untouched", {32'd0, rdata_o}, 64'h0280_0000);
    rd(5'h00); chk("R8 ctrl untouched", {32'd0, rdata_o}, 64'h1);
    // R2 disable again
    tag = "R2"; wr(5'h00, 0); ticks(10);
    rd(5'h04); chk("R2 status off", {32'd0, rdata_o}, 64'd0);
    summary();
  end
endmodule